// File: doc/BRIEF.md
# Stallable, Flushable Instruction Control Pipeline

This block is the chain of stage registers that moves the control part of an instruction through an in-order pipeline. Each stage register holds a valid bit, four side-effect indications (register write, memory write, branch, jump), a destination register number and a data word. The block also owns the fetch program counter. Stage 0 is the fetch-side register: it captures the instruction presented at the input ports. Each later stage captures the stage in front of it.

Every stage has a stall request and a flush request. A stall request on a stage also stalls every stage before it and the program counter. A stalled stage keeps its contents. The stage just after the last stalled stage receives a bubble, and all later stages keep advancing. A flush turns the instruction a stage would hold next cycle into a true no-operation, with every side-effect indication cleared, so that it cannot change architected state. Hazard detection logic drives the request vectors from the stage outputs. The register file, memories and branch logic act only on instructions that reach them with their indications set.

Top module: `pipe_ctl_chain`

## Requirements
- R1: While reset is asserted, every stage has valid, register-write, memory-write, branch, jump, destination and data equal to zero, and the program counter equals PC_RESET (default 0).
- R2: A stage that is not flushed, not stalled and whose predecessor is not stalled loads, on the next clock, the contents of its predecessor (for stage 0, the input ports).
- R3: A stage with its flush request bit set holds, after the next clock, valid, register-write, memory-write, branch, jump, destination and data all equal to zero.
- R4: When a stage is flushed and stalled in the same cycle, the flush wins and the stage holds the all-zero bubble of R3.
- R5: A stage whose effective stall is set and whose flush request is clear keeps its whole contents unchanged.
- R6: The effective stall output bit k equals the OR of stall request bits k through NSTAGE-1, so a request on any stage stalls every earlier stage.
- R7: A stage k>0 that is not stalled and not flushed while stage k-1 is stalled loads the all-zero bubble. Stages after it keep advancing.
- R8: While effective stall bit 0 is set, the program counter keeps its value.
- R9: While effective stall bit 0 is clear, the program counter advances by PC_STEP (default 4) each clock, modulo 2^PCW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Incoming instruction is real |
| in_wr_reg | input | 1 | Incoming register-write indication |
| in_wr_mem | input | 1 | Incoming memory-write indication |
| in_branch | input | 1 | Incoming branch indication |
| in_jump | input | 1 | Incoming jump indication |
| in_dst | input | REGW | Incoming destination register number |
| in_data | input | DATAW | Incoming data word |
| stall_req | input | NSTAGE | Stall request per stage (bit k = stage k) |
| flush_req | input | NSTAGE | Flush request per stage (bit k = stage k) |
| stall_eff | output | NSTAGE | Effective stall per stage after cascading |
| pc | output | PCW | Fetch program counter |
| st_valid | output | NSTAGE | Valid bit of each stage |
| st_wr_reg | output | NSTAGE | Register-write indication of each stage |
| st_wr_mem | output | NSTAGE | Memory-write indication of each stage |
| st_branch | output | NSTAGE | Branch indication of each stage |
| st_jump | output | NSTAGE | Jump indication of each stage |
| st_dst | output | NSTAGE*REGW | Destination per stage, stage k at bits k*REGW upward |
| st_data | output | NSTAGE*DATAW | Data per stage, stage k at bits k*DATAW upward |

## Verification
The bench targets a flush and a stall on the same stage. A design that lets the stall win would keep a live instruction with its write enables set. It also targets a stall request on the last stage only. A design that does not cascade would let earlier stages overwrite the frozen instruction, or move the program counter. It checks the stage right after a stalled one: a design that holds that stage, or copies the stalled instruction into it, would duplicate or stop the instruction flow. Long random runs mix all requests and check that payload bits and destination numbers are cleared on a flush, not only the valid bit.

// File: rtl/pipe_ctl_pkg.sv
`timescale 1ns/1ps
package pipe_ctl_pkg;

  typedef struct packed {
    logic valid;
    logic wr_reg;
    logic wr_mem;
    logic branch;
    logic jump;
  } ctl_flags_t;

  typedef enum logic [1:0] {
    UPD_LOAD   = 2'd0,
    UPD_FLUSH  = 2'd1,
    UPD_HOLD   = 2'd2,
    UPD_BUBBLE = 2'd3
  } upd_e;

  // Priority: flush, then own stall (hold), then upstream stall (bubble), else load.
  function automatic upd_e pick_update(input logic flush, input logic stall,
                                       input logic up_stall);
    if (flush)         return UPD_FLUSH;
    else if (stall)    return UPD_HOLD;
    else if (up_stall) return UPD_BUBBLE;
    else               return UPD_LOAD;
  endfunction

  function automatic logic has_side_effect(input ctl_flags_t f);
    return f.wr_reg | f.wr_mem | f.branch | f.jump;
  endfunction

endpackage

// File: rtl/stall_cascade.sv
`timescale 1ns/1ps
module stall_cascade #(
  parameter int NSTAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSTAGE-1:0] req_i,
  output logic [NSTAGE-1:0] eff_o
);

  genvar k;
  generate
    for (k = 0; k < NSTAGE; k++) begin : g_casc
      if (k == NSTAGE - 1) begin : g_last
        assign eff_o[k] = req_i[k];
      end else begin : g_mid
        assign eff_o[k] = req_i[k] | eff_o[k+1];
      end
    end
  endgenerate

  // R6: a request on the last stage freezes the whole chain
  assert_last_req_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_i[NSTAGE-1] |-> (&eff_o));

  // R6: no request anywhere means nothing stalls
  assert_no_req_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(req_i) == 0) |-> (eff_o == '0));

endmodule

// File: rtl/fetch_pc.sv
`timescale 1ns/1ps
module fetch_pc #(
  parameter int              PCW      = 32,
  parameter int              PC_STEP  = 4,
  parameter logic [PCW-1:0]  PC_RESET = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold_i,
  output logic [PCW-1:0] pc_o
);

  localparam logic [PCW-1:0] STEP_V = PCW'(PC_STEP);

  function automatic logic [PCW-1:0] pc_advance(input logic [PCW-1:0] p);
    return p + STEP_V;
  endfunction

  logic [PCW-1:0] pc_next;
  assign pc_next = hold_i ? pc_o : pc_advance(pc_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_o <= PC_RESET;
    else        pc_o <= pc_next;
  end

  assert_pc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(pc_o));

  assert_pc_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_i |=> (pc_o - $past(pc_o) == STEP_V));

endmodule

// File: rtl/pipe_stage.sv
`timescale 1ns/1ps
module pipe_stage
  import pipe_ctl_pkg::*;
#(
  parameter int REGW  = 5,
  parameter int DATAW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             stall_i,
  input  logic             up_stall_i,
  input  ctl_flags_t       d_flags,
  input  logic [REGW-1:0]  d_dst,
  input  logic [DATAW-1:0] d_data,
  output ctl_flags_t       q_flags,
  output logic [REGW-1:0]  q_dst,
  output logic [DATAW-1:0] q_data
);

  upd_e upd;
  assign upd = pick_update(flush_i, stall_i, up_stall_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_flags <= '0;
      q_dst   <= '0;
      q_data  <= '0;
    end else begin
      case (upd)
        UPD_FLUSH, UPD_BUBBLE: begin
          q_flags <= '0;
          q_dst   <= '0;
          q_data  <= '0;
        end
        UPD_HOLD: begin
          q_flags <= q_flags;
          q_dst   <= q_dst;
          q_data  <= q_data;
        end
        default: begin
          q_flags <= d_flags;
          q_dst   <= d_dst;
          q_data  <= d_data;
        end
      endcase
    end
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && !stall_i && !up_stall_i) |=>
      (q_flags == $past(d_flags) && q_dst == $past(d_dst) && q_data == $past(d_data)));

  assert_flush_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (!q_flags.valid && !has_side_effect(q_flags) && q_dst == '0 && q_data == '0));

  assert_flush_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && stall_i) |=> (q_flags == '0));

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i && !flush_i) |=> ($stable(q_flags) && $stable(q_dst) && $stable(q_data)));

  assert_bubble_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (up_stall_i && !stall_i && !flush_i) |=> (q_flags == '0));

endmodule

// File: rtl/pipe_ctl_chain.sv
`timescale 1ns/1ps
module pipe_ctl_chain
  import pipe_ctl_pkg::*;
#(
  parameter int             NSTAGE   = 2,
  parameter int             REGW     = 5,
  parameter int             DATAW    = 32,
  parameter int             PCW      = 32,
  parameter int             PC_STEP  = 4,
  parameter logic [PCW-1:0] PC_RESET = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_wr_reg,
  input  logic                    in_wr_mem,
  input  logic                    in_branch,
  input  logic                    in_jump,
  input  logic [REGW-1:0]         in_dst,
  input  logic [DATAW-1:0]        in_data,
  input  logic [NSTAGE-1:0]       stall_req,
  input  logic [NSTAGE-1:0]       flush_req,
  output logic [NSTAGE-1:0]       stall_eff,
  output logic [PCW-1:0]          pc,
  output logic [NSTAGE-1:0]       st_valid,
  output logic [NSTAGE-1:0]       st_wr_reg,
  output logic [NSTAGE-1:0]       st_wr_mem,
  output logic [NSTAGE-1:0]       st_branch,
  output logic [NSTAGE-1:0]       st_jump,
  output logic [NSTAGE*REGW-1:0]  st_dst,
  output logic [NSTAGE*DATAW-1:0] st_data
);

  ctl_flags_t       in_flags;
  ctl_flags_t       s_flags [NSTAGE];
  logic [REGW-1:0]  s_dst   [NSTAGE];
  logic [DATAW-1:0] s_data  [NSTAGE];
  logic [NSTAGE-1:0] up_stall;

  assign in_flags = '{valid: in_valid, wr_reg: in_wr_reg, wr_mem: in_wr_mem,
                      branch: in_branch, jump: in_jump};

  stall_cascade #(.NSTAGE(NSTAGE)) u_casc (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (stall_req),
    .eff_o (stall_eff)
  );

  fetch_pc #(.PCW(PCW), .PC_STEP(PC_STEP), .PC_RESET(PC_RESET)) u_pc (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold_i (stall_eff[0]),
    .pc_o   (pc)
  );

  genvar k;
  generate
    for (k = 0; k < NSTAGE; k++) begin : g_stage
      ctl_flags_t       d_flags;
      logic [REGW-1:0]  d_dst;
      logic [DATAW-1:0] d_data;

      if (k == 0) begin : g_head
        assign up_stall[k] = 1'b0;
        assign d_flags     = in_flags;
        assign d_dst       = in_dst;
        assign d_data      = in_data;
      end else begin : g_body
        assign up_stall[k] = stall_eff[k-1];
        assign d_flags     = s_flags[k-1];
        assign d_dst       = s_dst[k-1];
        assign d_data      = s_data[k-1];
      end

      pipe_stage #(.REGW(REGW), .DATAW(DATAW)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush_req[k]),
        .stall_i    (stall_eff[k]),
        .up_stall_i (up_stall[k]),
        .d_flags    (d_flags),
        .d_dst      (d_dst),
        .d_data     (d_data),
        .q_flags    (s_flags[k]),
        .q_dst      (s_dst[k]),
        .q_data     (s_data[k])
      );

      assign st_valid[k]                = s_flags[k].valid;
      assign st_wr_reg[k]               = s_flags[k].wr_reg;
      assign st_wr_mem[k]               = s_flags[k].wr_mem;
      assign st_branch[k]               = s_flags[k].branch;
      assign st_jump[k]                 = s_flags[k].jump;
      assign st_dst[k*REGW +: REGW]     = s_dst[k];
      assign st_data[k*DATAW +: DATAW]  = s_data[k];
    end
  endgenerate

  // R1: the pipeline comes out of reset empty with the reset PC
  assert_reset_empty_R1: assert property (@(posedge clk)
    !rst_n |-> (st_valid == '0 && st_wr_reg == '0 && st_wr_mem == '0 && pc == PC_RESET));

endmodule

// File: tb/pipe_ctl_chain_tb.sv
`timescale 1ns/1ps
module pipe_ctl_chain_tb;

  localparam int N    = 3;
  localparam int RW   = 5;
  localparam int DW   = 32;
  localparam int PW   = 32;
  localparam int STEP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          in_valid, in_wr_reg, in_wr_mem, in_branch, in_jump;
  logic [RW-1:0] in_dst;
  logic [DW-1:0] in_data;
  logic [N-1:0]  stall_req, flush_req;
  logic [N-1:0]  stall_eff;
  logic [PW-1:0] pc;
  logic [N-1:0]  st_valid, st_wr_reg, st_wr_mem, st_branch, st_jump;
  logic [N*RW-1:0] st_dst;
  logic [N*DW-1:0] st_data;

  pipe_ctl_chain #(.NSTAGE(N), .REGW(RW), .DATAW(DW), .PCW(PW), .PC_STEP(STEP)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_wr_reg(in_wr_reg), .in_wr_mem(in_wr_mem),
    .in_branch(in_branch), .in_jump(in_jump), .in_dst(in_dst), .in_data(in_data),
    .stall_req(stall_req), .flush_req(flush_req), .stall_eff(stall_eff), .pc(pc),
    .st_valid(st_valid), .st_wr_reg(st_wr_reg), .st_wr_mem(st_wr_mem),
    .st_branch(st_branch), .st_jump(st_jump), .st_dst(st_dst), .st_data(st_data)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model: per stage a 5-bit flag word {valid,wr_reg,wr_mem,branch,jump}
  logic [4:0]    m_flg  [N];
  logic [RW-1:0] m_dst  [N];
  logic [DW-1:0] m_data [N];
  logic [PW-1:0] m_pc;
  string         m_tag  [N];
  string         pc_tag;

  function automatic logic [N-1:0] ref_eff(input logic [N-1:0] r);
    logic [N-1:0] e;
    logic acc;
    acc = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      acc  = acc | r[k];
      e[k] = acc;
    end
    return e;
  endfunction

  task automatic chk(input string tag, input string what, input int stg,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s stage %0d: got %0h expected %0h", tag, what, stg, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < N; k++) begin
      m_flg[k] = '0; m_dst[k] = '0; m_data[k] = '0; m_tag[k] = "R1";
    end
    m_pc = '0;
    pc_tag = "R1";
  endtask

  task automatic model_step();
    logic [N-1:0]  es;
    logic [4:0]    of [N];
    logic [RW-1:0] od [N];
    logic [DW-1:0] oa [N];
    logic          up;
    es = ref_eff(stall_req);
    of = m_flg; od = m_dst; oa = m_data;
    for (int k = 0; k < N; k++) begin
      up = (k > 0) ? es[k-1] : 1'b0;
      if (flush_req[k]) begin
        m_flg[k] = '0; m_dst[k] = '0; m_data[k] = '0;
        m_tag[k] = es[k] ? "R4" : "R3";
      end else if (es[k]) begin
        m_tag[k] = "R5";
      end else if (up) begin
        m_flg[k] = '0; m_dst[k] = '0; m_data[k] = '0;
        m_tag[k] = "R7";
      end else begin
        if (k == 0) begin
          m_flg[k]  = {in_valid, in_wr_reg, in_wr_mem, in_branch, in_jump};
          m_dst[k]  = in_dst;
          m_data[k] = in_data;
        end else begin
          m_flg[k] = of[k-1]; m_dst[k] = od[k-1]; m_data[k] = oa[k-1];
        end
        m_tag[k] = "R2";
      end
    end
    if (es[0]) pc_tag = "R8";
    else begin
      m_pc = m_pc + PW'(STEP);
      pc_tag = "R9";
    end
  endtask

  always @(posedge clk) if (rst_n) model_step();

  task automatic compare_all();
    for (int k = 0; k < N; k++) begin
      chk(m_tag[k], "flags", k,
          64'({st_valid[k], st_wr_reg[k], st_wr_mem[k], st_branch[k], st_jump[k]}),
          64'(m_flg[k]));
      chk(m_tag[k], "dst", k, 64'(st_dst[k*RW +: RW]), 64'(m_dst[k]));
      chk(m_tag[k], "data", k, 64'(st_data[k*DW +: DW]), 64'(m_data[k]));
    end
    chk(pc_tag, "pc", 0, 64'(pc), 64'(m_pc));
  endtask

  task automatic drive(input logic [N-1:0] s, input logic [N-1:0] f);
    in_valid  = 1'($urandom_range(0, 1));
    in_wr_reg = 1'($urandom_range(0, 1));
    in_wr_mem = 1'($urandom_range(0, 1));
    in_branch = 1'($urandom_range(0, 1));
    in_jump   = 1'($urandom_range(0, 1));
    in_dst    = RW'($urandom);
    in_data   = $urandom;
    stall_req = s;
    flush_req = f;
  endtask

  initial begin
    logic [N-1:0] s, f;
    model_reset();
    in_valid = 0; in_wr_reg = 0; in_wr_mem = 0; in_branch = 0; in_jump = 0;
    in_dst = '0; in_data = '0; stall_req = '0; flush_req = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    compare_all();
    chk("R1", "valid", 0, 64'(st_valid), 64'(0));
    rst_n = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      compare_all();
      if (i < 12) begin
        s = '0; f = '0;                        // R2: free flow
      end else if (i == 12) begin
        s = 3'b010; f = 3'b010;                // R4: flush and stall same stage
      end else if (i == 13) begin
        s = 3'b100; f = '0;                    // R6: last stage stall freezes all
      end else if (i == 14) begin
        s = 3'b001; f = '0;                    // R7: bubble behind stage 0
      end else if (i == 15) begin
        s = '0; f = 3'b111;                    // R3: flush everything
      end else begin
        s = '0; f = '0;
        for (int k = 0; k < N; k++) begin
          s[k] = ($urandom_range(0, 5) == 0);
          f[k] = ($urandom_range(0, 9) == 0);
        end
      end
      drive(s, f);
      #1;
      chk("R6", "stall_eff", 0, 64'(stall_eff), 64'(ref_eff(stall_req)));
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule